// File: doc/BRIEF.md
# Mailbox Request Sequencer

This block is a host-side engine for a doorbell mailbox. It takes one request at a time from a valid/ready interface. A request carries a 16-bit command, 16-bit control flags and three 64-bit payload words. The engine stamps a wrapping sequence number into the first outgoing word and waits until the remote side reports that its inbox is free. It then writes the four command registers and rings the remote doorbell. It drives the mailbox registers through a simple request/acknowledge register bus.

When the request asks for an answer, the engine waits for the host doorbell interrupt under a timeout that depends on the command class. On that interrupt it reads the host doorbell, then reads the four response words. It compares the echoed sequence number with the one it sent and clears the host doorbell. It reports a 12-bit primary status and the sequence number with a one-cycle completion pulse. If the remote signals that it came back from a reset, the request in flight is sent again from the start.

Timeouts are counted in clock ticks. A parameter gives the number of ticks per millisecond, so that short runs can use small values.

Top module: `mbx_seq`

## Requirements
- R1: Command word 0 is `{16'h0000, flags, seq, cmd}`: flags in bits [47:32], sequence number in bits [31:16], command in bits [15:0]. Words 1 to 3 are the payload words. The four words are written in order to bus addresses 0, 1, 2, 3, and each bus request holds its address, direction and data until it is acknowledged.
- R2: The sequence number is 1 for the first request after reset and advances by one for each accepted request. When the next value would equal `SEQ_MAX` (default 16'hFFFF), it returns to 1, so `SEQ_MAX` and 0 are never used.
- R3: Before any command write, the engine reads the remote doorbell at address 8. It reads it again for as long as bit 63 of the returned value is set.
- R4: After word 3 is written, the engine writes 64'h8000_0000_0000_0000 to the remote doorbell set alias at address 10'd9 (address 9).
- R5: If flag bit 8 (value 0x0100) is clear, the request completes right after the doorbell write, with primary status 0 and no further bus access.
- R6: The wait for a response is bounded by a limit given in milliseconds times `TICKS_PER_MS`. Class (command bits [15:8]) D1, D4, D5, D6 and D7 use `SHORT_MS` (100). Classes D2 and D3 use `LONG_MS` (30000), and so does command D705 alone within class D7. Any other class gets a zero limit.
- R7: A timeout completes the request with primary status 0x0FE.
- R8: While the engine waits, a high `hostIrq` makes it read the host doorbell at address 10. If bit 63 is set, it reads response addresses 4 to 7 once each and writes 0 to the host doorbell clear alias at address 11. It then completes with primary status equal to bits [59:48] of response word 0.
- R9: If bits [31:16] of response word 0 differ from the sequence number that was sent, the request completes with primary status 0x003.
- R10: If the host doorbell read shows bit 60 set, the engine clears the doorbell (address 11, data 0). It then resends the same request from the remote doorbell poll onward, with the same sequence number. It does not complete the request at that point.
- R11: An error flagged with a bus acknowledge completes the request at once with primary status 0x0FE. No further bus access follows.
- R12: A host doorbell read with neither bit 63 nor bit 60 set is followed by a clear write to address 11, and the engine returns to waiting without completing.
- R13: `reqReady` is high only while no request is in flight. `doneValid` is a single-cycle pulse after which the engine is ready again, and no bus access occurs while it is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Engine idle, request accepted on this cycle if valid |
| reqCmd | input | 16 | Command, class in bits [15:8] |
| reqFlags | input | 16 | Control flags, bit 8 requests a response |
| reqWord1 | input | 64 | Payload word 1 |
| reqWord2 | input | 64 | Payload word 2 |
| reqWord3 | input | 64 | Payload word 3 |
| busReq | output | 1 | Register bus access request |
| busWrite | output | 1 | 1 for write, 0 for read |
| busAddr | output | 4 | Mailbox register address |
| busWdata | output | 64 | Write data |
| busRdata | input | 64 | Read data, valid with busAck |
| busAck | input | 1 | Access complete |
| busErr | input | 1 | Access failed, valid with busAck |
| hostIrq | input | 1 | Host doorbell has a pending event |
| doneValid | output | 1 | Completion pulse |
| donePrimary | output | 12 | Primary status of the completed request |
| doneSeq | output | 16 | Sequence number of the completed request |

## Verification
A wrong sequence counter shows up at once in bits [31:16] of the first command write and in `doneSeq`. A wrongly decoded class or a faulty timer shows up as a completion whose distance from the doorbell write is off by about 100 or 30000 ticks, or which happens almost at once. Errors in the control path show up in the bus write log of the same request: a skipped poll, a missing clear, a second ring that never comes after a reset-return event, or a completion that arrives too early after a spurious doorbell.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam int ADDR_W     = 4;
  localparam int CMD_WORDS  = 4;
  localparam int DATA_WORDS = CMD_WORDS - 1;
  localparam int IDX_W      = $clog2(CMD_WORDS);

  // Mailbox register map as seen on the register bus
  localparam logic [ADDR_W-1:0] ADR_CMD0    = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_RSP0    = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_RBELL   = 4'd8;
  localparam logic [ADDR_W-1:0] ADR_RBELL_S = 4'd9;
  localparam logic [ADDR_W-1:0] ADR_HBELL   = 4'd10;
  localparam logic [ADDR_W-1:0] ADR_HBELL_C = 4'd11;

  localparam int BELL_BIT  = 63;
  localparam int RETRY_BIT = 60;
  localparam logic [63:0] RING_WORD = 64'h8000_0000_0000_0000;

  localparam int FLAG_RESP_BIT = 8;

  localparam logic [11:0] PRIM_OK     = 12'h000;
  localparam logic [11:0] PRIM_SEQERR = 12'h003;
  localparam logic [11:0] PRIM_FAIL   = 12'h0FE;

  typedef enum logic [1:0] {WSEL_CMD, WSEL_RING, WSEL_ZERO} wsel_e;
  typedef enum logic [1:0] {STAT_OK, STAT_RESP, STAT_SEQERR, STAT_FAIL} stat_e;
  typedef enum logic [1:0] {TMO_NONE, TMO_SHORT, TMO_LONG} tmo_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic             load;
    logic             timerClr;
    logic             timerRun;
    logic             capRsp;
    logic             setStat;
    stat_e            statSel;
    wsel_e            wSel;
    logic [IDX_W-1:0] wordIdx;
  } ctl_t;

  function automatic tmo_e classTmo(input logic [15:0] cmd);
    tmo_e r;
    case (cmd[15:8])
      8'hD1, 8'hD4, 8'hD5, 8'hD6: r = TMO_SHORT;
      8'hD2, 8'hD3:               r = TMO_LONG;
      8'hD7:                      r = (cmd == 16'hD705) ? TMO_LONG : TMO_SHORT;
      default:                    r = TMO_NONE;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mbx_datapath.sv
module mbx_datapath
  import mbx_pkg::*;
#(
  parameter logic [15:0] SEQ_MAX      = 16'hFFFF,
  parameter int unsigned TICKS_PER_MS = 100000,
  parameter int unsigned SHORT_MS     = 100,
  parameter int unsigned LONG_MS      = 30000
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctl_t        ctl,
  input  logic [15:0] reqCmd,
  input  logic [15:0] reqFlags,
  input  logic [63:0] reqData [DATA_WORDS],
  input  logic [11:0] rdPrim,
  input  logic [15:0] rdSeq,
  output logic [63:0] busWdata,
  output logic        needResp,
  output logic        timeoutHit,
  output logic        seqOk,
  output logic [11:0] donePrimary,
  output logic [15:0] doneSeq
);

  localparam longint unsigned SHORT_T = longint'(SHORT_MS) * longint'(TICKS_PER_MS);
  localparam longint unsigned LONG_T  = longint'(LONG_MS) * longint'(TICKS_PER_MS);
  localparam int TMR_W = $clog2(LONG_T + 1) < 1 ? 1 : $clog2(LONG_T + 1);

  logic [63:0]      cmdWord [CMD_WORDS];
  logic [15:0]      seqCnt, seqNext, curSeq;
  logic [TMR_W-1:0] timerCnt, timerLim;
  logic [11:0]      rspPrim;
  logic [15:0]      rspSeq;

  // Sequence counter skips the reserved top value and zero
  assign seqNext = (seqCnt + 16'd1 == SEQ_MAX) ? 16'd1 : seqCnt + 16'd1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqCnt   <= 16'd1;
      curSeq   <= 16'd0;
      needResp <= 1'b0;
      timerLim <= '0;
      for (int i = 0; i < CMD_WORDS; i++) cmdWord[i] <= '0;
    end else if (ctl.load) begin
      seqCnt     <= seqNext;
      curSeq     <= seqCnt;
      needResp   <= reqFlags[FLAG_RESP_BIT];
      cmdWord[0] <= {16'h0000, reqFlags, seqCnt, reqCmd};
      for (int i = 0; i < DATA_WORDS; i++) cmdWord[i+1] <= reqData[i];
      case (classTmo(reqCmd))
        TMO_SHORT: timerLim <= TMR_W'(SHORT_T);
        TMO_LONG:  timerLim <= TMR_W'(LONG_T);
        default:   timerLim <= '0;
      endcase
    end
  end

  // Response timer
  assign timeoutHit = (timerCnt >= timerLim);

  always_ff @(posedge clk) begin
    if (!rstN)                            timerCnt <= '0;
    else if (ctl.timerClr)                timerCnt <= '0;
    else if (ctl.timerRun && !timeoutHit) timerCnt <= timerCnt + 1'b1;
  end

  // Response capture and check
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspPrim <= '0;
      rspSeq  <= '0;
    end else if (ctl.capRsp) begin
      rspPrim <= rdPrim;
      rspSeq  <= rdSeq;
    end
  end

  assign seqOk = (rspSeq == curSeq);

  always_ff @(posedge clk) begin
    if (!rstN) donePrimary <= PRIM_OK;
    else if (ctl.setStat) begin
      case (ctl.statSel)
        STAT_OK:     donePrimary <= PRIM_OK;
        STAT_RESP:   donePrimary <= rspPrim;
        STAT_SEQERR: donePrimary <= PRIM_SEQERR;
        default:     donePrimary <= PRIM_FAIL;
      endcase
    end
  end

  assign doneSeq = curSeq;

  always_comb begin
    case (ctl.wSel)
      WSEL_CMD:  busWdata = cmdWord[ctl.wordIdx];
      WSEL_RING: busWdata = RING_WORD;
      default:   busWdata = '0;
    endcase
  end

  AST_SEQ_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (seqCnt != 16'd0) && (seqCnt != SEQ_MAX)); // R2
  AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(seqCnt)); // R2
  AST_FAIL_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.setStat && ctl.statSel == STAT_FAIL) |=> donePrimary == PRIM_FAIL); // R7

endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              hostIrq,
  input  logic              busAck,
  input  logic              busErr,
  input  logic              rdBell,
  input  logic              rdRetry,
  input  logic              needResp,
  input  logic              timeoutHit,
  input  logic              seqOk,
  output logic              busReq,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic              doneValid,
  output ctl_t              ctl
);

  typedef enum logic [3:0] {
    S_IDLE, S_POLL, S_WCMD, S_RING, S_WAIT, S_RDBELL, S_RRSP, S_CLR, S_DONE
  } state_e;
  typedef enum logic [1:0] {EV_NONE, EV_RESP, EV_RETRY} evt_e;

  state_e           state, stateNxt;
  evt_e             evt, evtNxt;
  logic [IDX_W-1:0] idx, idxNxt;
  logic             lastIdx;

  assign lastIdx   = (idx == IDX_W'(CMD_WORDS - 1));
  assign reqReady  = (state == S_IDLE);
  assign doneValid = (state == S_DONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      evt   <= EV_NONE;
      idx   <= '0;
    end else begin
      state <= stateNxt;
      evt   <= evtNxt;
      idx   <= idxNxt;
    end
  end

  always_comb begin
    stateNxt    = state;
    evtNxt      = evt;
    idxNxt      = idx;
    busReq      = 1'b0;
    busWrite    = 1'b0;
    busAddr     = ADR_RBELL;
    ctl         = '0;
    ctl.wordIdx = idx;
    ctl.wSel    = WSEL_CMD;
    ctl.statSel = STAT_OK;

    case (state)
      S_IDLE: begin
        if (reqValid) begin
          ctl.load = 1'b1;
          stateNxt = S_POLL;
        end
      end

      S_POLL: begin
        busReq  = 1'b1;
        busAddr = ADR_RBELL;
        if (busAck) begin
          if (busErr) begin
            ctl.setStat = 1'b1; ctl.statSel = STAT_FAIL; stateNxt = S_DONE;
          end else if (!rdBell) begin
            idxNxt   = '0;
            stateNxt = S_WCMD;
          end
        end
      end

      S_WCMD: begin
        busReq   = 1'b1;
        busWrite = 1'b1;
        busAddr  = ADR_CMD0 + ADDR_W'(idx);
        if (busAck) begin
          if (busErr) begin
            ctl.setStat = 1'b1; ctl.statSel = STAT_FAIL; stateNxt = S_DONE;
          end else if (lastIdx) begin
            stateNxt = S_RING;
          end else begin
            idxNxt = idx + 1'b1;
          end
        end
      end

      S_RING: begin
        busReq   = 1'b1;
        busWrite = 1'b1;
        busAddr  = ADR_RBELL_S;
        ctl.wSel = WSEL_RING;
        if (busAck) begin
          if (busErr) begin
            ctl.setStat = 1'b1; ctl.statSel = STAT_FAIL; stateNxt = S_DONE;
          end else if (needResp) begin
            ctl.timerClr = 1'b1;
            stateNxt     = S_WAIT;
          end else begin
            ctl.setStat = 1'b1; ctl.statSel = STAT_OK; stateNxt = S_DONE;
          end
        end
      end

      S_WAIT: begin
        ctl.timerRun = 1'b1;
        if (timeoutHit) begin
          ctl.setStat = 1'b1; ctl.statSel = STAT_FAIL; stateNxt = S_DONE;
        end else if (hostIrq) begin
          stateNxt = S_RDBELL;
        end
      end

      S_RDBELL: begin
        busReq  = 1'b1;
        busAddr = ADR_HBELL;
        if (busAck) begin
          if (busErr) begin
            ctl.setStat = 1'b1; ctl.statSel = STAT_FAIL; stateNxt = S_DONE;
          end else if (rdRetry) begin
            evtNxt = EV_RETRY; stateNxt = S_CLR;
          end else if (rdBell) begin
            evtNxt = EV_RESP; idxNxt = '0; stateNxt = S_RRSP;
          end else begin
            evtNxt = EV_NONE; stateNxt = S_CLR;
          end
        end
      end

      S_RRSP: begin
        busReq     = 1'b1;
        busAddr    = ADR_RSP0 + ADDR_W'(idx);
        ctl.capRsp = busAck && !busErr && (idx == '0);
        if (busAck) begin
          if (busErr) begin
            ctl.setStat = 1'b1; ctl.statSel = STAT_FAIL; stateNxt = S_DONE;
          end else if (lastIdx) begin
            stateNxt = S_CLR;
          end else begin
            idxNxt = idx + 1'b1;
          end
        end
      end

      S_CLR: begin
        busReq   = 1'b1;
        busWrite = 1'b1;
        busAddr  = ADR_HBELL_C;
        ctl.wSel = WSEL_ZERO;
        if (busAck) begin
          if (busErr) begin
            ctl.setStat = 1'b1; ctl.statSel = STAT_FAIL; stateNxt = S_DONE;
          end else begin
            case (evt)
              EV_RETRY: stateNxt = S_POLL;
              EV_RESP: begin
                ctl.setStat = 1'b1;
                ctl.statSel = seqOk ? STAT_RESP : STAT_SEQERR;
                stateNxt    = S_DONE;
              end
              default: stateNxt = S_WAIT;
            endcase
          end
        end
      end

      S_DONE:  stateNxt = S_IDLE;
      default: stateNxt = S_IDLE;
    endcase
  end

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck) |=> (busReq && $stable(busAddr) && $stable(busWrite))); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> (!doneValid && reqReady)); // R13

endmodule

// File: rtl/mbx_seq.sv
module mbx_seq
  import mbx_pkg::*;
#(
  parameter logic [15:0] SEQ_MAX      = 16'hFFFF,
  parameter int unsigned TICKS_PER_MS = 100000,
  parameter int unsigned SHORT_MS     = 100,
  parameter int unsigned LONG_MS      = 30000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [15:0] reqCmd,
  input  logic [15:0] reqFlags,
  input  logic [63:0] reqWord1,
  input  logic [63:0] reqWord2,
  input  logic [63:0] reqWord3,
  output logic        busReq,
  output logic        busWrite,
  output logic [3:0]  busAddr,
  output logic [63:0] busWdata,
  input  logic [63:0] busRdata,
  input  logic        busAck,
  input  logic        busErr,
  input  logic        hostIrq,
  output logic        doneValid,
  output logic [11:0] donePrimary,
  output logic [15:0] doneSeq
);

  ctl_t        ctl;
  logic        needResp, timeoutHit, seqOk;
  logic [63:0] dataArr [DATA_WORDS];
  logic        unusedRd;

  assign dataArr[0] = reqWord1;
  assign dataArr[1] = reqWord2;
  assign dataArr[2] = reqWord3;
  assign unusedRd   = ^{busRdata[62:61], busRdata[47:32], busRdata[15:0]};

  mbx_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqReady   (reqReady),
    .hostIrq    (hostIrq),
    .busAck     (busAck),
    .busErr     (busErr),
    .rdBell     (busRdata[BELL_BIT]),
    .rdRetry    (busRdata[RETRY_BIT]),
    .needResp   (needResp),
    .timeoutHit (timeoutHit),
    .seqOk      (seqOk),
    .busReq     (busReq),
    .busWrite   (busWrite),
    .busAddr    (busAddr),
    .doneValid  (doneValid),
    .ctl        (ctl)
  );

  mbx_datapath #(
    .SEQ_MAX      (SEQ_MAX),
    .TICKS_PER_MS (TICKS_PER_MS),
    .SHORT_MS     (SHORT_MS),
    .LONG_MS      (LONG_MS)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .reqCmd      (reqCmd),
    .reqFlags    (reqFlags),
    .reqData     (dataArr),
    .rdPrim      (busRdata[59:48]),
    .rdSeq       (busRdata[31:16]),
    .busWdata    (busWdata),
    .needResp    (needResp),
    .timeoutHit  (timeoutHit),
    .seqOk       (seqOk),
    .donePrimary (donePrimary),
    .doneSeq     (doneSeq)
  );

  AST_RING_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busWrite && busAddr == ADR_RBELL_S) |-> busWdata == RING_WORD); // R4
  AST_CLEAR_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busWrite && busAddr == ADR_HBELL_C) |-> busWdata == 64'd0); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !busReq); // R13

endmodule

// File: tb/mbx_seq_tb.sv
module mbx_seq_tb;

  localparam logic [15:0] SEQ_MAX = 16'd6;
  localparam int TPM = 1;
  localparam logic [63:0] BELL  = 64'h8000_0000_0000_0000;
  localparam logic [63:0] RETRY = 64'h1000_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [15:0] reqCmd = '0, reqFlags = '0;
  logic [63:0] reqWord1 = '0, reqWord2 = '0, reqWord3 = '0;
  logic        busReq, busWrite;
  logic [3:0]  busAddr;
  logic [63:0] busWdata;
  logic [63:0] busRdata = '0;
  logic        busAck = 1'b0, busErr = 1'b0;
  logic        hostIrq;
  logic        doneValid;
  logic [11:0] donePrimary;
  logic [15:0] doneSeq;

  // slave model state
  logic [63:0] hdb = '0;
  logic [3:0]  logA [256];
  logic [63:0] logD [256];
  int logN = 0, ringCnt = 0, ringCyc = 0, cyc = 0, rd8 = 0, rd8AtCmd0 = 0, rdRsp = 0;
  int busyUntil = 0;
  logic        errEn = 1'b0;
  logic [3:0]  errAddr = '0;
  logic [63:0] rsp0Val = '0;
  logic        injGo = 1'b0;
  logic [63:0] injVal = '0;
  // completion monitor
  int doneCnt = 0, doneCyc = 0;
  logic [11:0] gotPrim = '0;
  logic [15:0] gotSeq = '0;
  // bookkeeping
  int total = 0, bad = 0;
  logic [15:0] expSeq = 16'd1;

  always #5 clk = ~clk;
  assign hostIrq = |hdb;

  mbx_seq #(.SEQ_MAX(SEQ_MAX), .TICKS_PER_MS(TPM), .SHORT_MS(100), .LONG_MS(30000)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqCmd(reqCmd), .reqFlags(reqFlags), .reqWord1(reqWord1), .reqWord2(reqWord2),
    .reqWord3(reqWord3), .busReq(busReq), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busAck(busAck), .busErr(busErr),
    .hostIrq(hostIrq), .doneValid(doneValid), .donePrimary(donePrimary), .doneSeq(doneSeq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (injGo) hdb <= injVal;
    if (busAck) begin
      busAck <= 1'b0;
      busErr <= 1'b0;
      if (busWrite && !busErr) begin
        logA[logN % 256] <= busAddr;
        logD[logN % 256] <= busWdata;
        logN <= logN + 1;
        if (busAddr == 4'd11) hdb <= hdb & busWdata;
        if (busAddr == 4'd9) begin ringCnt <= ringCnt + 1; ringCyc <= cyc; end
        if (busAddr == 4'd0) rd8AtCmd0 <= rd8;
      end
    end else if (busReq) begin
      busAck <= 1'b1;
      busErr <= errEn && (busAddr == errAddr);
      if (!busWrite) begin
        case (busAddr)
          4'd8: begin busRdata <= (rd8 < busyUntil) ? BELL : 64'd0; rd8 <= rd8 + 1; end
          4'd10: busRdata <= hdb;
          4'd4: begin busRdata <= rsp0Val; rdRsp <= rdRsp + 1; end
          4'd5, 4'd6, 4'd7: begin busRdata <= 64'hA5A5_0000_5A5A_0000; rdRsp <= rdRsp + 1; end
          default: busRdata <= 64'd0;
        endcase
      end
    end
  end

  always @(posedge clk) begin
    if (doneValid) begin
      doneCnt <= doneCnt + 1;
      gotPrim <= donePrimary;
      gotSeq  <= doneSeq;
      doneCyc <= cyc;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic sendReq(input logic [15:0] cmd, input logic [15:0] flg, output logic [15:0] s);
    s = expSeq;
    expSeq = (expSeq + 16'd1 == SEQ_MAX) ? 16'd1 : expSeq + 16'd1;
    @(negedge clk);
    reqCmd = cmd; reqFlags = flg;
    reqWord1 = {48'h1111_2222_3333, cmd}; reqWord2 = 64'h4444_5555_6666_7777;
    reqWord3 = {32'h8888_9999, 16'h0, s};
    reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitRing(input int n);
    int k = 0;
    while (ringCnt < n && k < 1000) begin @(negedge clk); k++; end
  endtask

  task automatic inject(input logic [63:0] v);
    @(negedge clk);
    injVal = v; injGo = 1'b1;
    @(negedge clk);
    injGo = 1'b0;
  endtask

  task automatic waitDone(input int prev, input string req);
    int k = 0;
    while (doneCnt <= prev && k < 40000) begin @(negedge clk); k++; end
    chk(req, 64'(doneCnt), 64'(prev + 1));
  endtask

  function automatic logic [63:0] mkRsp(input logic [11:0] prim, input logic [15:0] s, input logic [15:0] cmd);
    return {4'h0, prim, 16'h0, s, cmd};
  endfunction

  task automatic t_reset();
    chk("R13 ready after reset", 64'(reqReady), 64'd1);
    chk("R13 bus idle after reset", 64'(busReq), 64'd0);
    chk("R13 no done after reset", 64'(doneValid), 64'd0);
  endtask

  task automatic t_noresp();
    int base = logN, rbase = rd8, dprev = doneCnt;
    logic [15:0] s;
    busyUntil = rd8 + 2;
    sendReq(16'hD401, 16'h0002, s);
    waitDone(dprev, "R5 completes");
    chk("R5 primary", 64'(gotPrim), 64'h0);
    chk("R2 first seq", 64'(gotSeq), 64'(s));
    chk("R3 polls before cmd", 64'(rd8AtCmd0 - rbase), 64'd3);
    chk("R4 write count", 64'(logN - base), 64'd5);
    for (int k = 0; k < 4; k++) chk("R1 cmd address order", 64'(logA[(base + k) % 256]), 64'(k));
    chk("R1 word0 layout", logD[base % 256], {16'h0, 16'h0002, s, 16'hD401});
    chk("R1 word1", logD[(base + 1) % 256], {48'h1111_2222_3333, 16'hD401});
    chk("R1 word3", logD[(base + 3) % 256], {32'h8888_9999, 16'h0, s});
    chk("R4 ring address", 64'(logA[(base + 4) % 256]), 64'd9);
    chk("R4 ring data", logD[(base + 4) % 256], BELL);
    repeat (10) @(negedge clk);
    chk("R5 no access after done", 64'(logN - base), 64'd5);
  endtask

  task automatic t_resp_ok();
    int base = logN, rr = rdRsp, rc = ringCnt, dprev = doneCnt;
    logic [15:0] s;
    rsp0Val = mkRsp(12'h123, expSeq, 16'hD702);
    sendReq(16'hD702, 16'h0100, s);
    waitRing(rc + 1);
    repeat (3) @(negedge clk);
    chk("R13 busy while waiting", 64'(reqReady), 64'd0);
    inject(BELL);
    waitDone(dprev, "R8 completes");
    chk("R8 primary from response", 64'(gotPrim), 64'h123);
    chk("R2 seq", 64'(gotSeq), 64'(s));
    chk("R8 four response reads", 64'(rdRsp - rr), 64'd4);
    chk("R8 clear address", 64'(logA[(logN - 1) % 256]), 64'd11);
    chk("R8 clear data", logD[(logN - 1) % 256], 64'd0);
    chk("R8 write count", 64'(logN - base), 64'd6);
  endtask

  task automatic t_seq_err();
    int rc = ringCnt, dprev = doneCnt;
    logic [15:0] s;
    rsp0Val = mkRsp(12'h055, expSeq ^ 16'h0040, 16'hD401);
    sendReq(16'hD401, 16'h0100, s);
    waitRing(rc + 1);
    inject(BELL);
    waitDone(dprev, "R9 completes");
    chk("R9 sequence mismatch status", 64'(gotPrim), 64'h003);
  endtask

  task automatic t_timeout(input logic [15:0] cmd, input int lim);
    int rc = ringCnt, dprev = doneCnt, d;
    logic [15:0] s;
    sendReq(cmd, 16'h0100, s);
    waitRing(rc + 1);
    waitDone(dprev, "R7 completes");
    chk("R7 timeout status", 64'(gotPrim), 64'h0FE);
    d = doneCyc - ringCyc;
    total++;
    if (d < lim + 1 || d > lim + 3) begin
      bad++;
      $display("FAIL R6 class %0h delay act=%0d exp=%0d", cmd, d, lim + 2);
    end
  endtask

  task automatic t_retry();
    int base = logN, rc = ringCnt, dprev = doneCnt;
    logic [15:0] s;
    rsp0Val = mkRsp(12'h000, expSeq, 16'hD401);
    sendReq(16'hD401, 16'h0100, s);
    waitRing(rc + 1);
    inject(RETRY);
    waitRing(rc + 2);
    chk("R10 no completion on retry", 64'(doneCnt), 64'(dprev));
    chk("R10 clear before resend", 64'(logA[(base + 5) % 256]), 64'd11);
    chk("R10 resend word0", logD[(base + 6) % 256], logD[base % 256]);
    chk("R10 resend ring", 64'(logA[(base + 10) % 256]), 64'd9);
    inject(BELL);
    waitDone(dprev, "R10 completes");
    chk("R10 status after resend", 64'(gotPrim), 64'h0);
    chk("R10 seq kept", 64'(gotSeq), 64'(s));
  endtask

  task automatic t_spurious();
    int rc = ringCnt, dprev = doneCnt;
    logic [15:0] s;
    rsp0Val = mkRsp(12'h007, expSeq, 16'hD401);
    sendReq(16'hD401, 16'h0100, s);
    waitRing(rc + 1);
    inject(64'h4000_0000_0000_0000);
    repeat (20) @(negedge clk);
    chk("R12 no completion", 64'(doneCnt), 64'(dprev));
    chk("R12 cleared", 64'(logA[(logN - 1) % 256]), 64'd11);
    chk("R12 irq dropped", 64'(hostIrq), 64'd0);
    inject(BELL);
    waitDone(dprev, "R12 completes");
    chk("R12 later response", 64'(gotPrim), 64'h007);
  endtask

  task automatic t_bus_err();
    int base = logN, rc = ringCnt, dprev = doneCnt;
    logic [15:0] s;
    errEn = 1'b1; errAddr = 4'd2;
    sendReq(16'hD401, 16'h0000, s);
    waitDone(dprev, "R11 completes");
    chk("R11 error status", 64'(gotPrim), 64'h0FE);
    repeat (10) @(negedge clk);
    chk("R11 writes stop", 64'(logN - base), 64'd2);
    chk("R11 no ring", 64'(ringCnt), 64'(rc));
    errEn = 1'b0;
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 7; i++) begin
      int dprev = doneCnt;
      logic [15:0] s;
      sendReq(16'hD101, 16'h0000, s);
      waitDone(dprev, "R2 completes");
      chk("R2 wrapping seq", 64'(gotSeq), 64'(s));
      chk("R1 stamped seq", 64'(logD[(logN - 5) % 256][31:16]), 64'(s));
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_noresp();
    t_resp_ok();
    t_seq_err();
    t_timeout(16'hD101, 100 * TPM);
    t_timeout(16'hD701, 100 * TPM);
    t_timeout(16'hD601, 100 * TPM);
    t_timeout(16'h1201, 0);
    t_timeout(16'hD705, 30000 * TPM);
    t_timeout(16'hD301, 30000 * TPM);
    t_retry();
    t_spurious();
    t_bus_err();
    t_wrap();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R13 watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule